// File: doc/BRIEF.md
# Single and Repeating Pulse Sequencer

This block is a small clocked state machine that turns a start level into output pulses. While idle it waits for the start input. Once started, it walks through a fixed short sequence and raises a pulse output for one state of that sequence. It also holds a busy level for as long as the sequence is in progress.

A repeat input chooses what happens after the pulse. With repeat low, the machine parks in a hold state until start is released, so exactly one pulse leaves per start assertion. With repeat high, the machine cycles back and issues a pulse every second clock for as long as repeat stays high.

A build-time parameter replaces the registered (Moore) pulse with a clock-gated (Mealy) pulse. That pulse is high only during the low half of the clock period in the pulse state. In that variant the repeat input has no effect.

The reset input is asynchronous and active low. It is released through a short synchroniser.

Top module: `pulse_seq_fsm`

## Requirements
- R1: While `rst_n` is low, `pulse_o` and `active_o` are 0 without waiting for a clock edge. After `rst_n` rises, the machine sits idle for the two clock edges of the release synchroniser and only then responds to `start_i`.
- R2: From idle, the machine stays idle while `start_i` is 0. It enters the pulse state on the first rising edge that sees `start_i` at 1.
- R3: From the pulse state, the machine always moves to the gap state on the next edge, whatever the inputs are.
- R4: From the gap state with `repeat_i` at 0, the machine moves to the hold state. It stays in the hold state while `start_i` is 1 and returns to idle on the first edge that sees `start_i` at 0.
- R5: In the Moore build (`MEALY_OUT`=0), the gap state with `repeat_i` at 1 returns to the pulse state. This gives a pulse on every second cycle for as long as `repeat_i` is held.
- R6: In the Moore build, `pulse_o` is 1 for the whole clock period in the pulse state and 0 in every other state.
- R7: `active_o` is 1 in the pulse, gap and hold states and 0 only in idle. When `repeat_i` is 0, `active_o` stays high for max(h,3) cycles after start is held for h cycles.
- R8: If `repeat_i` is 0 before `start_i` rises, exactly one pulse appears per start assertion, however long start is held.
- R9: In the Mealy build (`MEALY_OUT`=1), `repeat_i` is ignored. `pulse_o` equals "pulse state AND clock low", so it is 0 during the high phase of the clock and 1 during the low phase of the single pulse-state cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, state changes on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start level; holding it high keeps the one-shot in hold |
| repeat_i | input | 1 | 1 selects the repeating pulse train (Moore build only) |
| pulse_o | output | 1 | Pulse output |
| active_o | output | 1 | High while a sequence is in progress |

## Verification
The bench sweeps the start hold length from one to five cycles for both repeat values. It checks the pulse count and the length of the busy window against closed-form counts. A short hold of one cycle catches a design that makes the pulse-to-gap step depend on start: such a design would fall back to idle early and cut the busy window below three cycles.

A repeat sweep catches a design that sends the gap state to hold regardless of repeat, because the pulse train would then stop after one pulse. The Mealy instance is sampled in both clock phases, which exposes a pulse that is not gated by the clock or that still follows repeat. A reset applied mid-sequence must clear both outputs at once, before the next clock edge.

// File: rtl/pulse_seq_pkg.sv
package pulse_seq_pkg;
  // Gray-ordered encoding: every legal step flips one register bit.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_PULSE = 2'b10,
    ST_GAP   = 2'b11,
    ST_HOLD  = 2'b01
  } pseq_state_e;
endpackage

// File: rtl/pulse_seq_rst_sync.sv
module pulse_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pulse_seq_next.sv
module pulse_seq_next
  import pulse_seq_pkg::*;
#(
  parameter bit MEALY = 1'b0
) (
  input  pseq_state_e cur_st,
  input  logic        start_i,
  input  logic        repeat_i,
  output pseq_state_e nxt_st
);
  logic loop_en;

  generate
    if (MEALY) begin : g_no_loop
      assign loop_en = 1'b0;
    end else begin : g_loop
      assign loop_en = repeat_i;
    end
  endgenerate

  always_comb begin
    nxt_st = cur_st;
    unique case (cur_st)
      ST_IDLE:  nxt_st = start_i ? ST_PULSE : ST_IDLE;
      ST_PULSE: nxt_st = ST_GAP;
      ST_GAP:   nxt_st = loop_en ? ST_PULSE : ST_HOLD;
      ST_HOLD:  nxt_st = start_i ? ST_HOLD : ST_IDLE;
      default:  nxt_st = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/pulse_seq_out.sv
module pulse_seq_out
  import pulse_seq_pkg::*;
#(
  parameter bit MEALY = 1'b0
) (
  input  logic        clk,
  input  pseq_state_e cur_st,
  output logic        pulse_o,
  output logic        active_o
);
  logic in_pulse;

  assign in_pulse = cur_st[1] & ~cur_st[0];
  assign active_o = cur_st[1] | cur_st[0];

  generate
    if (MEALY) begin : g_mealy
      assign pulse_o = in_pulse & ~clk;
    end else begin : g_moore
      assign pulse_o = in_pulse;
    end
  endgenerate
endmodule

// File: rtl/pulse_seq_fsm.sv
module pulse_seq_fsm
  import pulse_seq_pkg::*;
#(
  parameter bit MEALY_OUT  = 1'b0,
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic repeat_i,
  output logic pulse_o,
  output logic active_o
);
  logic        rst_sync_n;
  pseq_state_e state_q;
  pseq_state_e state_d;

  pulse_seq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pulse_seq_next #(.MEALY(MEALY_OUT)) u_next (
    .cur_st   (state_q),
    .start_i  (start_i),
    .repeat_i (repeat_i),
    .nxt_st   (state_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  pulse_seq_out #(.MEALY(MEALY_OUT)) u_out (
    .clk      (clk),
    .cur_st   (state_q),
    .pulse_o  (pulse_o),
    .active_o (active_o)
  );
endmodule

// File: rtl/pulse_seq_chk.sv
module pulse_seq_chk
  import pulse_seq_pkg::*;
#(
  parameter bit MEALY = 1'b0
) (
  input logic        clk,
  input logic        srst_n,
  input logic        start_i,
  input logic        repeat_i,
  input logic        pulse_o,
  input logic        active_o,
  input pseq_state_e state
);
  assert_leave_idle_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_IDLE && start_i) |=> state == ST_PULSE);

  assert_pulse_to_gap_R3: assert property (@(posedge clk) disable iff (!srst_n)
    state == ST_PULSE |=> state == ST_GAP);

  assert_gap_stop_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_GAP && (!repeat_i || MEALY)) |=> state == ST_HOLD);

  assert_hold_release_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_HOLD && !start_i) |=> state == ST_IDLE);

  assert_gap_loop_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (!MEALY && state == ST_GAP && repeat_i) |=> state == ST_PULSE);

  assert_active_start_R7: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(active_o) |-> $past(start_i));

  assert_no_pulse_idle_R6: assert property (@(posedge clk) disable iff (!srst_n)
    !active_o |-> !pulse_o);
endmodule

bind pulse_seq_fsm pulse_seq_chk #(.MEALY(MEALY_OUT)) u_chk (
  .clk      (clk),
  .srst_n   (rst_sync_n),
  .start_i  (start_i),
  .repeat_i (repeat_i),
  .pulse_o  (pulse_o),
  .active_o (active_o),
  .state    (state_q)
);

// File: tb/pulse_seq_fsm_test.sv
module pulse_seq_fsm_test;
  logic clk = 1'b0;
  logic rst_n;
  logic start_i = 1'b0;
  logic repeat_i = 1'b0;
  logic p_mo, l_mo, p_ml, l_ml;
  int   tests = 0;
  int   fails = 0;
  bit   done = 1'b0;
  // model states: 0 idle, 1 pulse, 2 gap, 3 hold
  int   em = 0;
  int   eml = 0;
  int   cnt_p, cnt_l, cnt_pm, cnt_lm;

  always #10 clk = ~clk;  // 50 MHz

  pulse_seq_fsm #(.MEALY_OUT(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .repeat_i(repeat_i),
    .pulse_o(p_mo), .active_o(l_mo));

  pulse_seq_fsm #(.MEALY_OUT(1'b1)) uut_ml (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .repeat_i(repeat_i),
    .pulse_o(p_ml), .active_o(l_ml));

  function automatic int nxt(int st, logic s, logic r, bit ml);
    case (st)
      0:       return s ? 1 : 0;
      1:       return 2;
      2:       return (r && !ml) ? 1 : 3;
      default: return s ? 3 : 0;
    endcase
  endfunction

  function automatic string tag(int st, logic r, bit ml);
    case (st)
      0:       return "R2";
      1:       return "R3";
      2:       return (r && !ml) ? "R5" : "R4";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Inputs change 5 ns after the falling edge; checks at +5 (clk high) and +15 (clk low).
  task automatic step(input logic s, input logic r);
    string tm, tml;
    start_i = s;
    repeat_i = r;
    @(posedge clk);
    tm  = tag(em, r, 0);
    tml = tag(eml, r, 1);
    em  = nxt(em, s, r, 0);
    eml = nxt(eml, s, r, 1);
    #5;
    check({tm, "/R6 moore pulse"}, int'(p_mo), int'(em == 1));
    check({tm, "/R7 moore active"}, int'(l_mo), int'(em != 0));
    check({tml, "/R9 mealy pulse clk high"}, int'(p_ml), 0);
    check({tml, "/R7 mealy active"}, int'(l_ml), int'(eml != 0));
    cnt_p += int'(p_mo);
    cnt_l += int'(l_mo);
    cnt_lm += int'(l_ml);
    #10;
    check("R9 mealy pulse clk low", int'(p_ml), int'(eml == 1));
    cnt_pm += int'(p_ml);
  endtask

  task automatic clear_counts();
    cnt_p = 0; cnt_l = 0; cnt_pm = 0; cnt_lm = 0;
  endtask

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    #2;
    check("R1 reset pulse", int'(p_mo | p_ml), 0);
    check("R1 reset active", int'(l_mo | l_ml), 0);
    #40;
    @(negedge clk); #5;
    start_i = 1'b1;
    rst_n = 1'b1;
    // R1: two synchroniser edges during which start must be ignored
    @(posedge clk); #5;
    check("R1 sync edge 1", int'(l_mo | l_ml), 0);
    @(posedge clk); #5;
    check("R1 sync edge 2", int'(l_mo | l_ml), 0);
    #10;
    start_i = 1'b0;
    em = 0; eml = 0;
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);

    // One-shot sweep (R8, R7 window)
    for (int h = 1; h <= 5; h++) begin
      clear_counts();
      for (int i = 0; i < h; i++) step(1'b1, 1'b0);
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
      check("R8 one pulse", cnt_p, 1);
      check("R7 active window", cnt_l, (h > 3) ? h : 3);
      check("R9 mealy one pulse", cnt_pm, 1);
      check("R9 mealy window", cnt_lm, (h > 3) ? h : 3);
    end

    // Repeat sweep (R5 in Moore, R9 ignores repeat)
    for (int h = 1; h <= 5; h++) begin
      clear_counts();
      for (int i = 0; i < h; i++) step(1'b1, 1'b1);
      for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
      check("R5 train count", cnt_p, (h + 3 + 1) / 2);
      check("R9 mealy ignores repeat", cnt_pm, 1);
      for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
      check("R4 drained to idle", int'(l_mo), 0);
    end

    // R1: reset mid-sequence clears outputs before any edge
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R1 async clear pulse", int'(p_mo), 0);
    check("R1 async clear active", int'(l_mo | l_ml), 0);
    start_i = 1'b0;
    repeat_i = 1'b0;
    em = 0; eml = 0;
    #3 rst_n = 1'b1;
    #1;
    check("R1 stays idle after release", int'(l_mo | l_ml), 0);
    #10;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule